// File: doc/BRIEF.md
# CAN Transmit Message Scheduler

This block sits between the host's transmit storage and a CAN frame transmitter. The host writes messages either into a first-in first-out queue of parameterised depth or into a single high-priority slot. When the protocol engine reports an idle bus, the scheduler chooses one message and pulses a request. While an attempt is in flight it holds the chosen message steady on its outputs. A message leaves its storage only when the transmitter reports success.

A filled priority slot wins over the queue at the next idle-bus point. A queue frame that has already been requested is never displaced by a later write to the slot. If the attempt ends with an error or a lost arbitration, the block keeps the same source locked and requests the same message again at the next idle bus. Status outputs report queue occupancy, a sticky overflow flag and whether the priority slot holds a message. A completion pulse tells the host when a frame has gone out.

Top module: `can_tx_sched`

## Requirements
- R1: After reset the queue is empty (fifoEmpty=1, fillCount=0, fifoFull=0), prioPending=0, overflow=0, and txReq and doneIrq are 0.
- R2: Queue messages are sent in write order. fillCount follows each write and each removal, and fifoFull is 1 exactly when fillCount equals DEPTH (legal DEPTH is 2 to 63).
- R3: A queue write while fifoFull=1 is dropped, leaving fillCount and the stored messages unchanged. It sets overflow, which stays at 1 until reset.
- R4: The priority slot holds one message. A slot write while prioPending=1 is dropped and the held message is kept.
- R5: When busIdle is 1 in a clock with no attempt in flight and a message available, txReq is 1 for exactly the next clock. The outputs then carry the slot message if prioPending=1, otherwise the queue head. With nothing available, busIdle raises no request.
- R6: A slot write made while a queue frame is in flight does not change the message outputs or abort that frame. The slot message goes out at the following idle bus.
- R7: After txError or arbLost ends an attempt, the next busIdle raises txReq again with the same message and source, even if the slot was filled meanwhile. Nothing is removed.
- R8: A message is removed from the queue, or the slot is cleared, only by txDone ending an attempt. doneIrq is 1 for exactly the one clock after that txDone.
- R9: txDone, txError and arbLost that arrive when no attempt is in flight are ignored: fillCount, prioPending and doneIrq do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoWr | input | 1 | Write the wr* message into the queue |
| prioWr | input | 1 | Write the wr* message into the priority slot |
| wrId | input | 29 | Identifier of the written message |
| wrIde | input | 1 | Extended-identifier flag of the written message |
| wrRtr | input | 1 | Remote-request flag of the written message |
| wrDlc | input | 4 | Data length code of the written message |
| wrData | input | 64 | Payload of the written message |
| busIdle | input | 1 | Bus is idle and a frame may start |
| txDone | input | 1 | Transmitter finished the frame successfully |
| txError | input | 1 | Transmitter aborted the frame on an error |
| arbLost | input | 1 | Transmitter lost arbitration |
| txId | output | 29 | Identifier of the selected message |
| txIde | output | 1 | Extended-identifier flag of the selected message |
| txRtr | output | 1 | Remote-request flag of the selected message |
| txDlc | output | 4 | Data length code of the selected message |
| txData | output | 64 | Payload of the selected message |
| txReq | output | 1 | One-clock request to start sending the selected message |
| doneIrq | output | 1 | One-clock pulse after a successful transmission |
| fifoEmpty | output | 1 | Queue holds no message |
| fifoFull | output | 1 | Queue holds DEPTH messages |
| prioPending | output | 1 | Priority slot holds a message |
| fillCount | output | $clog2(DEPTH+1) | Number of messages in the queue |
| overflow | output | 1 | Sticky flag: a queue write was dropped |

## Verification
The hardest case to reach is a failed attempt that overlaps a new slot write. The failure has to occur after a queue frame has been requested, and the slot has to be filled during the failed attempt. The retry must still present the queue frame and not the newer slot message. The bench forces this by requesting a queue frame and ending it with txError, writing the slot, and then sending busIdle again. It then ends that retry with arbLost and repeats. A sweep over every queue fill level, with and without a slot message, confirms the order of departure from each starting state.

// File: rtl/can_tx_sched_pkg.sv
package can_tx_sched_pkg;

  typedef struct packed {
    logic [28:0] id;
    logic        ide;
    logic        rtr;
    logic [3:0]  dlc;
    logic [63:0] data;
  } txMsg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic popFifo;
    logic clrPrio;
    logic selPrio;
  } schedCtl_t;

endpackage

// File: rtl/can_tx_sched_dp.sv
module can_tx_sched_dp
  import can_tx_sched_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoWr,
  input  logic             prioWr,
  input  txMsg_t           wrMsg,
  input  schedCtl_t        ctl,
  output txMsg_t           outMsg,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic             prioPending,
  output logic [CNT_W-1:0] fillCount,
  output logic             overflow
);

  txMsg_t           mem [DEPTH];
  txMsg_t           prioMsg;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doWrite, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign fifoEmpty = (fillCount == '0);
  assign fifoFull  = (fillCount == CNT_W'(DEPTH));
  assign doWrite   = fifoWr && !fifoFull;
  assign doPop     = ctl.popFifo && !fifoEmpty;

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= wrMsg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
      overflow  <= 1'b0;
    end else begin
      if (doWrite) wrPtr <= nextPtr(wrPtr);
      if (doPop)   rdPtr <= nextPtr(rdPtr);
      case ({doWrite, doPop})
        2'b10:   fillCount <= fillCount + CNT_W'(1);
        2'b01:   fillCount <= fillCount - CNT_W'(1);
        default: fillCount <= fillCount;
      endcase
      if (fifoWr && fifoFull) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prioPending <= 1'b0;
      prioMsg     <= '0;
    end else if (ctl.clrPrio) begin
      prioPending <= 1'b0;
    end else if (prioWr && !prioPending) begin
      prioPending <= 1'b1;
      prioMsg     <= wrMsg;
    end
  end

  assign outMsg = ctl.selPrio ? prioMsg : mem[rdPtr];

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));
  a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWr && fifoFull && !ctl.popFifo) |=> (fillCount == $past(fillCount)));
  a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  a_r4_slot_kept: assert property (@(posedge clk) disable iff (!rstN)
    (prioPending && !ctl.clrPrio) |=> (prioPending && $stable(prioMsg)));
  a_r8_pop_needs_entry: assert property (@(posedge clk) disable iff (!rstN)
    ctl.popFifo |-> !fifoEmpty);
  a_r8_clear_needs_entry: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrPrio |-> prioPending);

endmodule

// File: rtl/can_tx_sched_ctrl.sv
module can_tx_sched_ctrl
  import can_tx_sched_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      busIdle,
  input  logic      txDone,
  input  logic      txError,
  input  logic      arbLost,
  input  logic      fifoEmpty,
  input  logic      prioPending,
  output schedCtl_t ctl,
  output logic      txReq,
  output logic      doneIrq
);

  typedef enum logic [1:0] {S_IDLE, S_ACTIVE, S_RETRY} schedState_t;

  schedState_t state;
  logic        selPrioQ;
  logic        haveMsg;
  logic        finish;

  assign haveMsg = prioPending || !fifoEmpty;
  assign finish  = (state == S_ACTIVE) && txDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      selPrioQ <= 1'b0;
      txReq    <= 1'b0;
      doneIrq  <= 1'b0;
    end else begin
      txReq   <= 1'b0;
      doneIrq <= 1'b0;
      case (state)
        S_IDLE: if (busIdle && haveMsg) begin
          selPrioQ <= prioPending;
          txReq    <= 1'b1;
          state    <= S_ACTIVE;
        end
        S_ACTIVE: begin
          if (txDone) begin
            doneIrq <= 1'b1;
            state   <= S_IDLE;
          end else if (txError || arbLost) begin
            state <= S_RETRY;
          end
        end
        S_RETRY: if (busIdle) begin
          txReq <= 1'b1;
          state <= S_ACTIVE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ctl.selPrio = selPrioQ;
  assign ctl.popFifo = finish && !selPrioQ;
  assign ctl.clrPrio = finish && selPrioQ;

  a_r5_req_single: assert property (@(posedge clk) disable iff (!rstN)
    txReq |=> !txReq);
  a_r5_no_req_without_msg: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !haveMsg) |=> !txReq);
  a_r7_source_locked: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |=> $stable(selPrioQ));
  a_r8_irq_follows_done: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> $past(txDone));
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
  import can_tx_sched_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoWr,
  input  logic             prioWr,
  input  logic [28:0]      wrId,
  input  logic             wrIde,
  input  logic             wrRtr,
  input  logic [3:0]       wrDlc,
  input  logic [63:0]      wrData,
  input  logic             busIdle,
  input  logic             txDone,
  input  logic             txError,
  input  logic             arbLost,
  output logic [28:0]      txId,
  output logic             txIde,
  output logic             txRtr,
  output logic [3:0]       txDlc,
  output logic [63:0]      txData,
  output logic             txReq,
  output logic             doneIrq,
  output logic             fifoEmpty,
  output logic             fifoFull,
  output logic             prioPending,
  output logic [CNT_W-1:0] fillCount,
  output logic             overflow
);

  txMsg_t    wrMsg, outMsg;
  schedCtl_t ctl;

  assign wrMsg = '{id: wrId, ide: wrIde, rtr: wrRtr, dlc: wrDlc, data: wrData};
  assign txId   = outMsg.id;
  assign txIde  = outMsg.ide;
  assign txRtr  = outMsg.rtr;
  assign txDlc  = outMsg.dlc;
  assign txData = outMsg.data;

  can_tx_sched_dp #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .fifoWr(fifoWr), .prioWr(prioWr), .wrMsg(wrMsg),
    .ctl(ctl), .outMsg(outMsg), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .prioPending(prioPending), .fillCount(fillCount), .overflow(overflow)
  );

  can_tx_sched_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busIdle(busIdle), .txDone(txDone),
    .txError(txError), .arbLost(arbLost), .fifoEmpty(fifoEmpty),
    .prioPending(prioPending), .ctl(ctl), .txReq(txReq), .doneIrq(doneIrq)
  );

endmodule

// File: tb/can_tx_sched_tb.sv
`timescale 1ns/1ps
module can_tx_sched_tb_top;

  localparam int DEPTH = 4;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoWr = 0, prioWr = 0, busIdle = 0, txDone = 0, txError = 0, arbLost = 0;
  logic [28:0] wrId = '0;
  logic wrIde = 0, wrRtr = 0;
  logic [3:0] wrDlc = '0;
  logic [63:0] wrData = '0;
  logic [28:0] txId;
  logic txIde, txRtr, txReq, doneIrq, fifoEmpty, fifoFull, prioPending, overflow;
  logic [3:0] txDlc;
  logic [63:0] txData;
  logic [CNT_W-1:0] fillCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  can_tx_sched #(.DEPTH(DEPTH)) dut_i (.*);

  function automatic logic [98:0] mk(input int k);
    logic [28:0] id;
    id = 29'(k * 12345 + 7);
    return {id, k[0], k[1], 4'(k % 9), 32'hA5A50000 + 32'(k), 32'(k * 3 + 1)};
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [98:0] act, input logic [98:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [98:0] outMsgV();
    return {txId, txIde, txRtr, txDlc, txData};
  endfunction

  task automatic put(input bit toPrio, input int k);
    {wrId, wrIde, wrRtr, wrDlc, wrData} = mk(k);
    if (toPrio) prioWr = 1; else fifoWr = 1;
    step();
    prioWr = 0;
    fifoWr = 0;
  endtask

  task automatic request(input string req, input int k);
    busIdle = 1;
    step();
    busIdle = 0;
    chk(req, 99'(txReq), 99'(1));
    chk(req, outMsgV(), mk(k));
    step();
    chk({req, " pulse"}, 99'(txReq), 99'(0));
  endtask

  task automatic finishOk(input string req, input int k);
    chk(req, outMsgV(), mk(k));
    txDone = 1;
    step();
    txDone = 0;
    chk({req, " irq"}, 99'(doneIrq), 99'(1));
    step();
    chk({req, " irq single"}, 99'(doneIrq), 99'(0));
  endtask

  task automatic sendOne(input string req, input int k);
    request(req, k);
    finishOk(req, k);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    // R1 reset state
    chk("R1 flags", {fifoEmpty, fifoFull, prioPending, overflow, txReq, doneIrq},
        99'b100000);
    chk("R1 count", 99'(fillCount), 99'(0));
    // R5 idle bus with nothing stored
    busIdle = 1; step(); busIdle = 0;
    chk("R5 no msg no req", 99'(txReq), 99'(0));

    // R2 fill, R3 overflow
    for (int i = 0; i < DEPTH; i++) begin
      put(0, i);
      chk("R2 count", 99'(fillCount), 99'(i + 1));
      chk("R2 full flag", 99'(fifoFull), 99'(i + 1 == DEPTH));
    end
    put(0, 99);
    chk("R3 count held", 99'(fillCount), 99'(DEPTH));
    chk("R3 overflow", 99'(overflow), 99'(1));
    for (int i = 0; i < DEPTH; i++) begin
      sendOne("R2 order", i);
      chk("R8 count after done", 99'(fillCount), 99'(DEPTH - 1 - i));
    end
    chk("R2 empty", 99'(fifoEmpty), 99'(1));
    chk("R3 overflow sticky", 99'(overflow), 99'(1));

    // R4, R5 priority slot
    put(0, 10); put(0, 11);
    put(1, 20);
    put(1, 21);
    chk("R4 pending", 99'(prioPending), 99'(1));
    sendOne("R5 prio first R4 kept", 20);
    chk("R8 slot cleared", 99'(prioPending), 99'(0));
    chk("R8 queue untouched", 99'(fillCount), 99'(2));
    sendOne("R2 after prio", 10);
    sendOne("R2 after prio", 11);

    // R6 slot write during in-flight queue frame
    put(0, 30);
    request("R6 queue req", 30);
    put(1, 40);
    chk("R6 msg stable", outMsgV(), mk(30));
    finishOk("R6 queue done", 30);
    sendOne("R6 prio next", 40);

    // R7 retry after error and lost arbitration
    put(0, 50); put(0, 51);
    request("R7 first", 50);
    txError = 1; step(); txError = 0;
    chk("R7 nothing removed", 99'(fillCount), 99'(2));
    chk("R7 no irq", 99'(doneIrq), 99'(0));
    put(1, 60);
    request("R7 retry same msg", 50);
    arbLost = 1; step(); arbLost = 0;
    request("R7 retry after arb", 50);
    finishOk("R7 done", 50);
    sendOne("R7 prio after", 60);
    // R9 strobes with nothing in flight
    txDone = 1; step(); txDone = 0;
    chk("R9 done ignored count", 99'(fillCount), 99'(1));
    chk("R9 done ignored irq", 99'(doneIrq), 99'(0));
    txError = 1; arbLost = 1; step(); txError = 0; arbLost = 0;
    sendOne("R9 normal after", 51);

    // sweep over fill levels with and without a slot message
    for (int n = 1; n <= DEPTH; n++) begin
      for (int p = 0; p < 2; p++) begin
        int base;
        base = 100 + n * 20 + p * 10;
        for (int i = 0; i < n; i++) put(0, base + i);
        if (p == 1) put(1, base + 9);
        chk("R2 sweep count", 99'(fillCount), 99'(n));
        if (p == 1) sendOne("R5 sweep prio", base + 9);
        for (int i = 0; i < n; i++) sendOne("R2 sweep order", base + i);
        chk("R2 sweep empty", {fifoEmpty, prioPending}, 99'b10);
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule